// File: doc/BRIEF.md
# Charger status and fault register

This block is one 16-bit word in the register file of a host-managed battery charger. The upper byte gives the host a live view of the charger's operating state, taken straight from the control core. The lower byte collects sticky fault flags. Two clear policies apply in the same word. Most fault bits clear as a side effect of the host reading the word. The two system-level faults, overvoltage and undervoltage, stay set until the host writes a zero to them.

The undervoltage flag is not set by a single event. The control core reports each failed restart attempt, and the flag sets only when a run of consecutive failures reaches a parameter count (default 7). A successful restart breaks the run. While either system fault is latched, the block holds the converter-disable output high. Removing the input source drops both system faults.

The host reaches the word through a simple strobed register bus: address, read strobe, write strobe and write data. Read data is registered and appears in the cycle after the read strobe.

Top module: `chg_status_reg`

## Requirements
- R1: Bits 15 down to 8 of the read word mirror `live_i[7:0]` as sampled in the read cycle. The order is: input present, current optimizer done, minimum-voltage protection mode active, input voltage regulation, input current regulation, fast charge, pre-charge, OTG mode. `rdata_o` shows the word in the cycle after `rd_i` is high with `addr_i` equal to `BLK_ADDR`.
- R2: A pulse on `rc_evt_i[5]`, `[4]`, `[3]`, `[2]`, `[1]` or `[0]` sets word bit 7, 6, 5, 2, 1 or 0 respectively. These are input overvoltage, battery discharge overcurrent, input overcurrent, forced converter off, OTG overvoltage and OTG undervoltage. A set bit stays set until a read of the word. The read returns the bit as set, and the bit is clear from the next cycle.
- R3: If an event arrives in the same cycle as the read that would clear its bit, the bit is still set after that read.
- R4: Bits 4 (system overvoltage) and 3 (system undervoltage) are not cleared by reads. A write with `wdata_i[4]`=0 clears bit 4, and a write with `wdata_i[3]`=0 clears bit 3. Writing 1 to either bit has no effect, and write data on every other bit position has no effect. When a set event and a clearing write arrive in the same cycle, the set wins.
- R5: A pulse on `sys_ov_evt_i` while input is present sets bit 4. `conv_dis_o` is high whenever bit 4 or bit 3 is set, and it stays high after the fault condition has gone away.
- R6: Bit 3 sets on the `RETRY_MAX`-th (default 7) `restart_fail_i` pulse with no `restart_ok_i` pulse in between. The count of failures returns to zero on `restart_ok_i`, on a write that clears bit 3, and while input is absent.
- R7: While `live_i[7]` (input present) is 0, bits 4 and 3 are cleared and held clear, and the events that would set them are ignored.
- R8: After reset every stored bit is 0, `rdata_o` is 0 and `conv_dis_o` is 0.
- R9: A read or write at any other address returns 0 on `rdata_o` and changes no stored bit. `rdata_o` is 0 in every cycle that follows a cycle without a read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| live_i | input | 8 | Live state levels, mirrored into word bits 15..8 |
| rc_evt_i | input | 6 | Fault event pulses for the read-clear bits 7,6,5,2,1,0 |
| sys_ov_evt_i | input | 1 | System overvoltage event pulse |
| restart_fail_i | input | 1 | Pulse for one failed restart attempt while system voltage is low |
| restart_ok_i | input | 1 | Pulse for a successful restart |
| addr_i | input | ADDR_W | Register bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| conv_dis_o | output | 1 | Converter disable, held by the latched system faults |

## Verification
Directed sequences separate the two clear policies by reading a word in which bits of both kinds are set. They also collide an event with the clearing read, and they send writes of ones, writes of zeros and writes at a foreign address. The restart counter is driven to six failures and then to seven. A success is inserted mid-run to show that the count restarts. Input removal is tried while both system latches are set. A long random phase then mixes every event, strobe and address choice against a cycle-level reference model, which exposes any ordering between set and clear that the directed cases miss.

// File: rtl/chg_status_pkg.sv
package chg_status_pkg;
    localparam int WORD_W = 16;
    localparam int LIVE_W = 8;
    localparam int RC_W   = 6;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [LIVE_W-1:0] live,
        input logic [RC_W-1:0]   rc,
        input logic              ov,
        input logic              uv
    );
        return {live, rc[5:3], ov, uv, rc[2:0]};
    endfunction
endpackage

// File: rtl/chg_rdclr_bank.sv
module chg_rdclr_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            flag_d[i] = evt_i[i] | (flag_q[i] & ~clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/chg_sys_latch.sv
module chg_sys_latch #(
    parameter int RETRY_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present_i,
    input  logic ov_evt_i,
    input  logic fail_i,
    input  logic ok_i,
    input  logic clr_ov_i,
    input  logic clr_uv_i,
    output logic ov_o,
    output logic uv_o
);
    localparam int CNT_W = $clog2(RETRY_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_MAX - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(RETRY_MAX);

    typedef struct packed {
        logic             ov;
        logic             uv;
        logic [CNT_W-1:0] cnt;
    } lat_t;

    lat_t st_d, st_q;
    logic uv_set, cnt_rst;

    always_comb begin
        st_d    = st_q;
        cnt_rst = !present_i || ok_i || clr_uv_i;
        uv_set  = present_i && !ok_i && fail_i && (st_q.cnt >= CNT_LAST);

        if (cnt_rst)                       st_d.cnt = '0;
        else if (fail_i && st_q.cnt < CNT_TOP) st_d.cnt = st_q.cnt + 1'b1;

        if (!present_i)     st_d.ov = 1'b0;
        else if (ov_evt_i)  st_d.ov = 1'b1;
        else if (clr_ov_i)  st_d.ov = 1'b0;

        if (!present_i)     st_d.uv = 1'b0;
        else if (uv_set)    st_d.uv = 1'b1;
        else if (clr_uv_i)  st_d.uv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ov_o = st_q.ov;
    assign uv_o = st_q.uv;
endmodule

// File: rtl/chg_status_reg.sv
module chg_status_reg #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BLK_ADDR  = 8'h20,
    parameter int                RETRY_MAX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        live_i,
    input  logic [5:0]        rc_evt_i,
    input  logic              sys_ov_evt_i,
    input  logic              restart_fail_i,
    input  logic              restart_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic              conv_dis_o
);
    import chg_status_pkg::*;

    logic              hit, rd_hit, wr_hit;
    logic [RC_W-1:0]   rc_q;
    logic              ov_q, uv_q;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    assign hit    = (addr_i == BLK_ADDR);
    assign rd_hit = rd_i && hit;
    assign wr_hit = wr_i && hit;

    chg_rdclr_bank #(.N(RC_W)) u_rc (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (rc_evt_i),
        .clr_i   (rd_hit),
        .flags_o (rc_q)
    );

    chg_sys_latch #(.RETRY_MAX(RETRY_MAX)) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .present_i (live_i[7]),
        .ov_evt_i  (sys_ov_evt_i),
        .fail_i    (restart_fail_i),
        .ok_i      (restart_ok_i),
        .clr_ov_i  (wr_hit && !wdata_i[4]),
        .clr_uv_i  (wr_hit && !wdata_i[3]),
        .ov_o      (ov_q),
        .uv_o      (uv_q)
    );

    always_comb begin
        rdata_d = rd_hit ? pack_word(live_i, rc_q, ov_q, uv_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o    = rdata_q;
    assign conv_dis_o = ov_q | uv_q;
endmodule

// File: rtl/chg_status_chk.sv
module chg_status_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BLK_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        live_i,
    input logic [5:0]        rc_evt_i,
    input logic              sys_ov_evt_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [15:0]       rdata_o,
    input logic              conv_dis_o,
    input logic [5:0]        rc_q
);
    logic rd_hit;
    assign rd_hit = rd_i && (addr_i == BLK_ADDR);

    p_rdclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> ((rc_q & ~$past(rc_evt_i)) == 6'd0));

    p_evt_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rc_evt_i != 6'd0) |=> ((rc_q & $past(rc_evt_i)) == $past(rc_evt_i)));

    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_dis_o && live_i[7] && !wr_i) |=> conv_dis_o);

    p_ov_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_i[7] && sys_ov_evt_i) |=> conv_dis_o);

    p_absent_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !live_i[7] |=> !conv_dis_o);

    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (rdata_o == 16'd0));
endmodule

bind chg_status_reg chg_status_chk #(.ADDR_W(ADDR_W), .BLK_ADDR(BLK_ADDR)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .live_i       (live_i),
    .rc_evt_i     (rc_evt_i),
    .sys_ov_evt_i (sys_ov_evt_i),
    .addr_i       (addr_i),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .rdata_o      (rdata_o),
    .conv_dis_o   (conv_dis_o),
    .rc_q         (rc_q)
);

// File: tb/chg_status_reg_tb_top.sv
module chg_status_reg_tb_top;
    localparam logic [7:0] A = 8'h20;
    localparam int RMAX = 7;

    logic clk = 0, rst_n = 0;
    logic [7:0]  live = 0;
    logic [5:0]  evt = 0;
    logic        ovev = 0, fail = 0, ok = 0, rd = 0, wr = 0;
    logic [7:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        cdis;

    int checks = 0, errors = 0, cyc = 0;

    logic [5:0]  m_rc;
    logic        m_ov, m_uv;
    int          m_cnt;
    logic [15:0] m_rdata;

    always #5 clk = ~clk;

    chg_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .live_i(live), .rc_evt_i(evt),
        .sys_ov_evt_i(ovev), .restart_fail_i(fail), .restart_ok_i(ok),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .conv_dis_o(cdis)
    );

    function automatic logic [15:0] word_of(logic [7:0] lv, logic [5:0] rc, logic ov, logic uv);
        return {lv, rc[5], rc[4], rc[3], ov, uv, rc[2], rc[1], rc[0]};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic hit, pres, cl_uv, uv_set, rst_c;
        hit   = (addr == A);
        pres  = live[7];
        cl_uv = wr && hit && !wdata[3];
        m_rdata = (rd && hit) ? word_of(live, m_rc, m_ov, m_uv) : 16'h0;
        m_rc  = ((rd && hit) ? 6'h0 : m_rc) | evt;
        uv_set = pres && !ok && fail && (m_cnt >= RMAX - 1);
        rst_c = !pres || ok || cl_uv;
        if (!pres) m_ov = 0;
        else if (ovev) m_ov = 1;
        else if (wr && hit && !wdata[4]) m_ov = 0;
        if (!pres) m_uv = 0;
        else if (uv_set) m_uv = 1;
        else if (cl_uv) m_uv = 0;
        if (rst_c) m_cnt = 0;
        else if (fail && m_cnt < RMAX) m_cnt++;
    endtask

    task automatic step(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " rdata"}, rdata, m_rdata);
        chk({tag, " conv_dis"}, {15'd0, cdis}, {15'd0, (m_ov | m_uv)});
        evt = 0; ovev = 0; fail = 0; ok = 0; rd = 0; wr = 0; wdata = 0; addr = A;
    endtask

    task automatic do_read(string tag);
        rd = 1; addr = A; step(tag);
    endtask

    task automatic do_write(string tag, logic [15:0] d);
        wr = 1; addr = A; wdata = d; step(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        m_rc = 0; m_ov = 0; m_uv = 0; m_cnt = 0; m_rdata = 0;
        addr = A;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 rdata at reset", rdata, 16'h0);
        chk("R8 conv_dis at reset", {15'd0, cdis}, 16'h0);
        rst_n = 1;
        @(negedge clk);
        do_read("R8 first read");

        // R1: live mirror under two patterns
        live = 8'hA5; do_read("R1 live A5");
        live = 8'hDA; do_read("R1 live DA");

        // R2: each read-clear bit sets and clears on read
        for (int i = 0; i < 6; i++) begin
            evt = 6'(1 << i); step("R2 set");
            do_read("R2 read shows set");
            do_read("R2 read after clear");
        end

        // R3: event with clearing read
        evt = 6'h21; step("R3 pre");
        rd = 1; evt = 6'h21; step("R3 collide");
        do_read("R3 still set");
        do_read("R3 now clear");

        // R5 and R4: overvoltage latch, reads keep it, write 1 no effect
        ovev = 1; step("R5 ov set");
        step("R5 held after event gone");
        do_read("R4 read keeps ov");
        do_write("R4 write ones", 16'hFFFF);
        do_read("R4 still set");
        addr = 8'h21; wr = 1; wdata = 16'h0; step("R9 foreign write");
        addr = 8'h21; rd = 1; step("R9 foreign read");
        do_read("R9 ov kept");
        do_write("R4 clear ov", 16'hFFEF);
        do_read("R4 ov cleared");
        ovev = 1; wr = 1; wdata = 16'h0; step("R4 set wins over clear");

        // R6: six failures, success, then seven
        do_write("R6 clear all", 16'h0);
        for (int i = 0; i < 6; i++) begin fail = 1; step("R6 fail"); end
        do_read("R6 six fails no uv");
        ok = 1; step("R6 success");
        for (int i = 0; i < 6; i++) begin fail = 1; step("R6 fail again"); end
        do_read("R6 still no uv");
        fail = 1; step("R6 seventh fail");
        do_read("R6 uv set");

        // R7: input removal clears both latches
        ovev = 1; step("R7 ov too");
        live = 8'h25; step("R7 absent");
        ovev = 1; step("R7 event ignored");
        do_read("R7 both clear");
        live = 8'hA5; step("R7 present again");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            live  = 8'($urandom);
            if ($urandom_range(0, 9) != 0) live[7] = 1;
            evt   = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
            ovev  = ($urandom_range(0, 19) == 0);
            fail  = ($urandom_range(0, 2) == 0);
            ok    = ($urandom_range(0, 24) == 0);
            rd    = ($urandom_range(0, 3) == 0);
            wr    = ($urandom_range(0, 9) == 0);
            wdata = 16'($urandom);
            addr  = ($urandom_range(0, 4) == 0) ? 8'($urandom) : A;
            step("R2 R4 R6 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule